// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a small 32-bit processor that fetches, decodes and retires one instruction on every rising clock edge. It runs nine instructions with fixed field positions. Five are register-to-register operations: add, subtract, AND, OR and signed set-on-less-than. The other four are load word, store word, branch-if-equal and an absolute jump. The instruction store and the data store are separate word-addressed arrays inside the core. Because they are separate, a fetch and a data access can happen in the same cycle.

The arrays are filled through a simple load port, which acts only while the synchronous reset is held. Once reset is released the core runs from address 0. It shows its progress on a trace interface. The trace carries the current program counter and instruction word, plus the register write and the memory write that will take effect at the coming clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst` is 1, the core makes no register or memory write and the PC is 0 after the edge. The load port writes `loadData` to word `loadAddr` of the instruction store (`loadSel`=0) or of the data store (`loadSel`=1), and it does so only while `rst` is 1. A load-port write outside reset has no effect on either store.
- R2: The fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. There is a 16-bit immediate in [15:0] and a 26-bit target in [25:0]. `instrOut` shows the word at `pcOut`. Any instruction other than a branch or a jump sets the next PC to PC+4.
- R3: Opcode 0 with funct 32 (add), 34 (subtract), 36 (AND), 37 (OR) or 42 (signed less-than, giving 1 or 0) writes its result to rd, with rs as the first operand and rt as the second.
- R4: Opcode 35 writes rt with the data word at the byte address rs + sign-extended immediate. The word index is address bits [MEM_AW+1:2].
- R5: Opcode 43 writes the value of rt to the data word at rs + sign-extended immediate. The trace shows the full byte address on `memWrAddr` and the data on `memWrData`. Only opcode 43 writes memory.
- R6: Register 0 reads as zero. A write aimed at it is dropped, so `regWrEn` is never 1 with `regWrAddr` 0.
- R7: Opcode 4 with equal rs and rt values sets the next PC to PC+4 + (sign-extended immediate × 4). With unequal values it sets PC+4.
- R8: Opcode 2 sets the next PC to {(PC+4)[31:28], target, 00}.
- R9: An opcode outside the set {0, 2, 4, 35, 43} is a no-op: no register write, no memory write, and PC+4. An R-type word with a funct outside the set {32, 34, 36, 37, 42} is handled the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Load-port write strobe (acts only in reset) |
| loadSel | input | 1 | 0 = instruction store, 1 = data store |
| loadAddr | input | MEM_AW | Word index for the load port |
| loadData | input | 32 | Word written by the load port |
| pcOut | output | 32 | Current program counter |
| instrOut | output | 32 | Instruction word being executed |
| regWrEn | output | 1 | Register write at the coming edge |
| regWrAddr | output | 5 | Destination register |
| regWrData | output | 32 | Value written to the register |
| memWrEn | output | 1 | Data-store write at the coming edge |
| memWrAddr | output | 32 | Byte address of the store |
| memWrData | output | 32 | Data stored |

## Verification
The bound checker watches five things on every cycle:
- the PC returns to zero after reset;
- the sequential PC+4 step for every opcode other than a branch or a jump;
- the jump target formed from the upper PC bits and the target field;
- that only loads and R-type words write registers, and only stores write memory;
- that register 0 is never written, and that unknown opcodes stay silent.

Some behaviours depend on register and memory contents, so only the bench's reference model can show them:
- ALU results;
- signed compares of mixed-sign values;
- loaded data and negative load offsets;
- taken versus not-taken branches, including a backward branch;
- that load-port writes outside reset leave both stores untouched.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    regDst;    // 1: destination is rd, 0: rt
    logic    aluSrc;    // 1: second operand is immediate
    logic    memToReg;  // 1: write back memory data
    logic    regWrite;
    logic    memWrite;
    logic    branch;
    logic    jump;
    alu_fn_e aluFn;
  } ctrl_t;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluFn = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.aluFn = ALU_ADD;
          FN_SUB:  ctrl.aluFn = ALU_SUB;
          FN_AND:  ctrl.aluFn = ALU_AND;
          FN_OR:   ctrl.aluFn = ALU_OR;
          FN_SLT:  ctrl.aluFn = ALU_SLT;
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluFn  = ALU_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  alu_fn_e      fn,
  output logic [W-1:0] result,
  output logic         isZero
);
  logic lessThan;

  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    unique case (fn)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(W-1){1'b0}}, lessThan};
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int MEM_AW = 8,
  localparam int DEPTH = 2 ** MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]   loadData,
  input  ctrl_t             ctrl,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   instrOut,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [XLEN-1:0]   regWrData,
  output logic              memWrEn,
  output logic [XLEN-1:0]   memWrAddr,
  output logic [XLEN-1:0]   memWrData
);
  logic [XLEN-1:0] imem [DEPTH];
  logic [XLEN-1:0] dmem [DEPTH];

  logic [XLEN-1:0]   pc, instr, rsVal, rtVal, immExt, aluB, aluY, memRd;
  logic [XLEN-1:0]   pcPlus4, branchTarget, jumpTarget, nextPc;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, dstIdx;
  logic              aluZero;

  assign instr  = imem[pc[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  sc_regfile #(.W(XLEN), .NREG(2 ** REG_AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (regWrEn),
    .wrAddr  (dstIdx),
    .wrData  (regWrData)
  );

  assign aluB = ctrl.aluSrc ? immExt : rtVal;

  sc_alu #(.W(XLEN)) u_alu (
    .opA    (rsVal),
    .opB    (aluB),
    .fn     (ctrl.aluFn),
    .result (aluY),
    .isZero (aluZero)
  );

  assign memRd     = dmem[aluY[MEM_AW+1:2]];
  assign dstIdx    = ctrl.regDst ? rdIdx : rtIdx;
  assign regWrData = ctrl.memToReg ? memRd : aluY;
  assign regWrEn   = ctrl.regWrite && !rst && (dstIdx != '0);
  assign regWrAddr = dstIdx;
  assign memWrEn   = ctrl.memWrite && !rst;
  assign memWrAddr = aluY;
  assign memWrData = rtVal;

  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jumpTarget   = {pcPlus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                    nextPc = jumpTarget;
    else if (ctrl.branch && aluZero)  nextPc = branchTarget;
    else                              nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadSel) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (loadEn && loadSel) dmem[loadAddr] <= loadData;
    end else if (memWrEn) begin
      dmem[aluY[MEM_AW+1:2]] <= rtVal;
    end
  end

  assign pcOut    = pc;
  assign instrOut = instr;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [31:0]       loadData,
  output logic [31:0]       pcOut,
  output logic [31:0]       instrOut,
  output logic              regWrEn,
  output logic [4:0]        regWrAddr,
  output logic [31:0]       regWrData,
  output logic              memWrEn,
  output logic [31:0]       memWrAddr,
  output logic [31:0]       memWrData
);
  ctrl_t      ctrl;
  logic [5:0] opcode, funct;

  sc_control u_ctrl (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .loadEn    (loadEn),
    .loadSel   (loadSel),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .ctrl      (ctrl),
    .opcode    (opcode),
    .funct     (funct),
    .pcOut     (pcOut),
    .instrOut  (instrOut),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instrOut,
  input logic        regWrEn,
  input logic [4:0]  regWrAddr,
  input logic        memWrEn
);
  logic [5:0] op;
  logic       knownOp;

  assign op      = instrOut[31:26];
  assign knownOp = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                   (op == 6'd35) || (op == 6'd43);

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pcOut == 32'd0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> !regWrEn && !memWrEn);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 6'd2 && op != 6'd4) |=> pcOut == $past(pcOut) + 32'd4);

  // R8
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> pcOut == {$past(pcOut + 32'd4) >> 28, $past(instrOut[25:0]), 2'b00});

  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> op == 6'd43);

  // R4
  regwr_src_chk: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> (op == 6'd0 || op == 6'd35));

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> regWrAddr != 5'd0);

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> !regWrEn && !memWrEn);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pcOut     (pcOut),
  .instrOut  (instrOut),
  .regWrEn   (regWrEn),
  .regWrAddr (regWrAddr),
  .memWrEn   (memWrEn)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  localparam int MAW   = 8;
  localparam int DEPTH = 2 ** MAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           loadEn = 1'b0;
  logic           loadSel = 1'b0;
  logic [MAW-1:0] loadAddr = '0;
  logic [31:0]    loadData = '0;
  logic [31:0]    pcOut, instrOut, regWrData, memWrAddr, memWrData;
  logic           regWrEn, memWrEn;
  logic [4:0]     regWrAddr;

  always #2 clk = ~clk;

  sc_core #(.MEM_AW(MAW)) u_dut (
    .clk (clk), .rst (rst), .loadEn (loadEn), .loadSel (loadSel),
    .loadAddr (loadAddr), .loadData (loadData), .pcOut (pcOut),
    .instrOut (instrOut), .regWrEn (regWrEn), .regWrAddr (regWrAddr),
    .regWrData (regWrData), .memWrEn (memWrEn), .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] mImem [DEPTH];
  logic [31:0] mDmem [DEPTH];
  logic [31:0] mRegs [32];
  logic [31:0] mPc;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int wordAddr);
    return {6'd2, 26'(wordAddr)};
  endfunction

  task automatic preload(input bit sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadAddr = MAW'(addr); loadData = data;
    if (sel) mDmem[addr] = data; else mImem[addr] = data;
    #1;
    check(pcOut == 32'd0, "R1 pc in reset", pcOut, 32'd0);
    check(!regWrEn && !memWrEn, "R1 quiet in reset", {30'd0, regWrEn, memWrEn}, 32'd0);
  endtask

  // Compare current outputs with the model, then advance the model one cycle.
  task automatic stepCompare();
    logic [31:0] ins, a, b, imm, res, addr, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    bit          we, mwe, valid;
    logic [4:0]  wa;
    string       tagW;
    ins = mImem[mPc[MAW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = mRegs[rs]; b = mRegs[rt];
    imm = {{16{ins[15]}}, ins[15:0]};
    nxt = mPc + 32'd4;
    we = 0; mwe = 0; wa = '0; res = '0; addr = '0; valid = 1;
    tagW = "R9";
    case (op)
      6'd0: begin
        tagW = "R3";
        case (fn)
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin valid = 0; tagW = "R9"; end
        endcase
        if (valid) begin
          if (rd != 0) begin we = 1; wa = rd; end else tagW = "R6";
        end
      end
      6'd35: begin
        tagW = (mPc == 32'd88) ? "R1" : "R4";
        addr = a + imm;
        res = mDmem[addr[MAW+1:2]];
        if (rt != 0) begin we = 1; wa = rt; end
      end
      6'd43: begin
        tagW = "R5";
        addr = a + imm;
        mwe = 1;
      end
      6'd4: begin
        tagW = "R7";
        if (a == b) nxt = mPc + 32'd4 + (imm << 2);
      end
      6'd2: begin
        tagW = "R8";
        nxt = {nxt[31:28], ins[25:0], 2'b00};
      end
      default: tagW = "R9";
    endcase

    check(pcOut == mPc, {tagW, " pc"}, pcOut, mPc);
    check(instrOut == ins, "R2 instr", instrOut, ins);
    check(regWrEn == we, {tagW, " regWrEn"}, {31'd0, regWrEn}, {31'd0, we});
    if (we) begin
      check(regWrAddr == wa, {tagW, " regWrAddr"}, {27'd0, regWrAddr}, {27'd0, wa});
      check(regWrData == res, {tagW, " regWrData"}, regWrData, res);
    end
    check(memWrEn == mwe, {tagW, " memWrEn"}, {31'd0, memWrEn}, {31'd0, mwe});
    if (mwe) begin
      check(memWrAddr == addr, "R5 memWrAddr", memWrAddr, addr);
      check(memWrData == b, "R5 memWrData", memWrData, b);
    end

    if (we) mRegs[wa] = res;
    if (mwe) mDmem[addr[MAW+1:2]] = b;
    mPc = nxt;
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finishUp();
  end

  initial begin
    logic [31:0] prog [24];
    for (int i = 0; i < DEPTH; i++) begin mImem[i] = '0; mDmem[i] = '0; end
    for (int i = 0; i < 32; i++) mRegs[i] = '0;
    mPc = '0;

    prog[0]  = encI(35, 0, 1, 0);        // r1 = 5
    prog[1]  = encI(35, 0, 2, 4);        // r2 = -7
    prog[2]  = encI(35, 0, 3, 8);        // r3 = pattern
    prog[3]  = encR(1, 2, 4, 32);        // add
    prog[4]  = encR(1, 2, 5, 34);        // sub
    prog[5]  = encR(3, 5, 6, 36);        // and
    prog[6]  = encR(3, 1, 7, 37);        // or
    prog[7]  = encR(2, 1, 8, 42);        // slt -7 < 5
    prog[8]  = encR(1, 2, 9, 42);        // slt 5 < -7
    prog[9]  = encR(1, 1, 0, 32);        // write to r0 dropped
    prog[10] = encI(43, 0, 0, 12);       // store r0
    prog[11] = encI(43, 0, 4, 16);       // store r4
    prog[12] = encI(35, 0, 10, 16);      // reload
    prog[13] = encI(4, 1, 2, 5);         // not taken
    prog[14] = encI(4, 10, 4, 2);        // taken to 17
    prog[15] = encR(1, 1, 11, 32);       // skipped
    prog[16] = encR(2, 2, 11, 32);       // skipped
    prog[17] = encI(63, 1, 12, 1);       // unknown opcode
    prog[18] = encR(1, 2, 13, 63);       // unknown funct
    prog[19] = encI(35, 5, 12, -4);      // negative offset
    prog[20] = encJ(22);                 // jump over 21
    prog[21] = encR(1, 1, 14, 32);       // skipped
    prog[22] = encI(35, 0, 15, 20);      // reads word 5
    prog[23] = encI(4, 0, 0, -1);        // backward self-loop

    repeat (2) @(negedge clk);
    for (int i = 0; i < 24; i++) preload(1'b0, i, prog[i]);
    preload(1'b1, 0, 32'd5);
    preload(1'b1, 1, 32'hFFFF_FFF9);
    preload(1'b1, 2, 32'h0F0F_00FF);
    preload(1'b1, 5, 32'h0000_1234);

    @(negedge clk);
    rst = 1'b0;
    loadEn = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (cyc > 0) @(negedge clk);
      // R1: load-port writes outside reset must change neither store
      if (cyc < 3) begin
        loadEn = 1'b1; loadSel = 1'b0; loadAddr = MAW'(22); loadData = 32'hFFFF_FFFF;
      end else if (cyc < 6) begin
        loadEn = 1'b1; loadSel = 1'b1; loadAddr = MAW'(5); loadData = 32'hDEAD_BEEF;
      end else begin
        loadEn = 1'b0;
      end
      #1;
      stepCompare();
    end
    finishUp();
  end
endmodule